// File: doc/BRIEF.md
# Page-Wrapping Address Pointer and Write Buffer

This block keeps the byte address and the pending write data for a serial memory of 4096 bytes, organised as 128 pages of 32 bytes. A serial framing layer sits in front of it. That layer reports bus events as one-cycle pulses: start, stop, a completed address phase, an accepted write byte and a transmitted read byte. The memory array sits behind the block. The block holds no framing logic and no array storage.

Bytes received during a write land in a 32-entry page buffer at the pointer's in-page offset. Each byte sets a bit in a valid mask. Only the low five pointer bits advance, so a long burst wraps within the page and overwrites older bytes. At the stop condition the block emits a single commit. The commit carries the page number, the 32-bit byte mask and the 256-bit page image, so the array can program every received byte in one write cycle. Reads use the same pointer as the read address and advance it across the whole array, wrapping from the last byte back to address 0. This one pointer supports current-address reads, random reads (a dummy write that loads the address) and sequential reads.

Top module: `ee_addr_page_ctl`

## Requirements
- R1: After reset the read address output is 0, no commit is signalled and the page buffer holds no valid byte.
- R2: An accepted write byte is stored at the offset given by pointer bits 4..0. Afterwards only those five bits advance by one (offset 31 goes to 0), and pointer bits 11..5 keep their value.
- R3: When more than 32 bytes arrive before a stop, the byte sent last to an offset replaces the earlier one at that offset in the commit.
- R4: A stop with at least one valid byte raises the commit valid output for exactly one cycle, in the cycle after the stop. The commit carries page number = pointer bits 11..5. Data byte k sits on bits 8k+7..8k of the data output.
- R5: A stop with no valid byte in the buffer produces no commit.
- R6: In a commit, mask bit k is 1 exactly for the offsets received since the last start or stop. Data lanes of unreceived offsets are zero.
- R7: After a commit the pointer holds the address that follows the last byte written, wrapped within its page.
- R8: An address load sets the full 12-bit pointer, visible on the read address output one cycle later. This lets a dummy write position a following read.
- R9: Each transmitted read byte advances the full 12-bit pointer by one, from 4095 to 0.
- R10: A start condition discards all uncommitted bytes, and a following stop without new bytes produces no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start or repeated start seen (pulse) |
| stop_i | input | 1 | Stop seen (pulse) |
| addr_load_i | input | 1 | Address phase complete, load pointer (pulse) |
| load_addr_i | input | 12 | Address to load |
| wr_byte_i | input | 1 | Write data byte accepted (pulse) |
| wr_data_i | input | 8 | Write data byte |
| rd_done_i | input | 1 | Read data byte transmitted (pulse) |
| rd_addr_o | output | 12 | Current pointer, used as read address |
| cmt_valid_o | output | 1 | Page commit request, one cycle |
| cmt_page_o | output | 7 | Page number of the commit |
| cmt_mask_o | output | 32 | Byte-valid mask of the commit |
| cmt_data_o | output | 256 | Page image, lane k at bits 8k+7..8k |

## Verification
A pointer that steps wrongly shows on the read address output in the very next cycle. An increment that carries into the page bits during writes appears as a changed page number at the commit. A stale or lost valid bit shows only at the next stop, as a wrong commit mask or a wrong data lane, or as a commit that is missing or spurious. The bench therefore checks the pointer after every event and compares the full commit image on every stop.

// File: rtl/ee_ap_pkg.sv
package ee_ap_pkg;
  typedef struct packed {
    logic stop;
    logic start;
    logic load;
    logic wr;
    logic rd;
  } ap_ev_t;
endpackage

// File: rtl/ee_ptr_unit.sv
module ee_ptr_unit
  import ee_ap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ap_ev_t            ev,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] ptr
);
  localparam int PG_W = ADDR_W - OFS_W;

  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] p);
    logic [OFS_W-1:0] o;
    o = p[OFS_W-1:0] + OFS_W'(1);
    return {p[ADDR_W-1:OFS_W], o};
  endfunction

  function automatic logic [ADDR_W-1:0] array_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  logic wr_step, rd_step, ld_step;
  assign ld_step = ev.load;
  assign wr_step = ev.wr;
  assign rd_step = ev.rd;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr <= '0;
    else if (ld_step) ptr <= load_addr;
    else if (wr_step) ptr <= page_step(ptr);
    else if (rd_step) ptr <= array_step(ptr);
  end

  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step && !ld_step |=> ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W]));
  assert_ofs_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step && !ld_step |=> ptr[OFS_W-1:0] == OFS_W'($past(ptr[OFS_W-1:0]) + 1'b1));
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_step |=> ptr == $past(load_addr));
  assert_rd_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step && !ld_step && !wr_step |=> ptr == ADDR_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf
  import ee_ap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5,
  parameter int DW     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ap_ev_t                ev,
  input  logic [ADDR_W-1:0]     ptr,
  input  logic [DW-1:0]         wr_data,
  output logic                  cmt_valid,
  output logic [ADDR_W-OFS_W-1:0] cmt_page,
  output logic [(1<<OFS_W)-1:0] cmt_mask,
  output logic [(1<<OFS_W)*DW-1:0] cmt_data
);
  localparam int NB   = 1 << OFS_W;
  localparam int PG_W = ADDR_W - OFS_W;

  logic [NB-1:0]    vmask;
  logic [OFS_W-1:0] ofs;
  logic             commit_fire;
  logic             drop_all;

  assign ofs         = ptr[OFS_W-1:0];
  assign commit_fire = ev.stop && (vmask != '0);
  assign drop_all    = ev.stop || ev.start;

  always_ff @(posedge clk) begin
    if (!rst_n)         vmask <= '0;
    else if (drop_all)  vmask <= '0;
    else if (ev.wr)     vmask <= vmask | (NB'(1) << ofs);
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           lane_q <= '0;
      else if (ev.wr && ofs == OFS_W'(g))   lane_q <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)           cmt_data[g*DW +: DW] <= '0;
      else if (commit_fire) cmt_data[g*DW +: DW] <= vmask[g] ? lane_q : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmt_valid <= 1'b0;
      cmt_mask  <= '0;
      cmt_page  <= '0;
    end else begin
      cmt_valid <= commit_fire;
      if (commit_fire) begin
        cmt_mask <= vmask;
        cmt_page <= ptr[ADDR_W-1:OFS_W];
      end
    end
  end

  assert_commit_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> cmt_mask != '0);
  assert_commit_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> !cmt_valid);
  assert_start_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev.start |=> vmask == '0);
  assert_fill_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev.wr && !drop_all |=> vmask[$past(ofs)]);
endmodule

// File: rtl/ee_addr_page_ctl.sv
module ee_addr_page_ctl
  import ee_ap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 5,
  parameter int DW     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        stop_i,
  input  logic                        addr_load_i,
  input  logic [ADDR_W-1:0]           load_addr_i,
  input  logic                        wr_byte_i,
  input  logic [DW-1:0]               wr_data_i,
  input  logic                        rd_done_i,
  output logic [ADDR_W-1:0]           rd_addr_o,
  output logic                        cmt_valid_o,
  output logic [ADDR_W-OFS_W-1:0]     cmt_page_o,
  output logic [(1<<OFS_W)-1:0]       cmt_mask_o,
  output logic [(1<<OFS_W)*DW-1:0]    cmt_data_o
);
  ap_ev_t ev;
  logic   bus_edge;

  // stop over start over load over write byte over read byte
  assign bus_edge = stop_i || start_i;
  assign ev.stop  = stop_i;
  assign ev.start = start_i && !stop_i;
  assign ev.load  = addr_load_i && !bus_edge;
  assign ev.wr    = wr_byte_i && !bus_edge && !addr_load_i;
  assign ev.rd    = rd_done_i && !bus_edge && !addr_load_i && !wr_byte_i;

  ee_ptr_unit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ev(ev), .load_addr(load_addr_i), .ptr(rd_addr_o)
  );

  ee_page_buf #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ptr(rd_addr_o), .wr_data(wr_data_i),
    .cmt_valid(cmt_valid_o), .cmt_page(cmt_page_o), .cmt_mask(cmt_mask_o),
    .cmt_data(cmt_data_o)
  );

  assert_commit_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> rd_addr_o == $past(rd_addr_o));
endmodule

// File: tb/sim_ee_addr_page_ctl.sv
module sim_ee_addr_page_ctl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 0, stop_i = 0, addr_load_i = 0, wr_byte_i = 0, rd_done_i = 0;
  logic [11:0]  load_addr_i = '0;
  logic [7:0]   wr_data_i = '0;
  logic [11:0]  rd_addr_o;
  logic         cmt_valid_o;
  logic [6:0]   cmt_page_o;
  logic [31:0]  cmt_mask_o;
  logic [255:0] cmt_data_o;

  always #5 clk = ~clk;

  ee_addr_page_ctl u0 (.*);

  int n_chk = 0, n_err = 0;
  logic [11:0] m_ptr = '0;
  logic [7:0]  m_buf [32];
  logic [31:0] m_mask = '0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] nxt_wr(input logic [11:0] p);
    return {p[11:5], 5'(p[4:0] + 5'd1)};
  endfunction

  function automatic logic [255:0] exp_image();
    logic [255:0] v = '0;
    for (int k = 0; k < 32; k++) if (m_mask[k]) v[k*8 +: 8] = m_buf[k];
    return v;
  endfunction

  task automatic tick_chk_ptr(input string req);
    @(negedge clk);
    start_i = 0; stop_i = 0; addr_load_i = 0; wr_byte_i = 0; rd_done_i = 0;
    chk(rd_addr_o == m_ptr, req, 256'(rd_addr_o), 256'(m_ptr));
  endtask

  task automatic do_load(input logic [11:0] a);
    addr_load_i = 1; load_addr_i = a; m_ptr = a;
    tick_chk_ptr("R8");
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_byte_i = 1; wr_data_i = d;
    m_buf[m_ptr[4:0]] = d; m_mask[m_ptr[4:0]] = 1'b1; m_ptr = nxt_wr(m_ptr);
    tick_chk_ptr("R2");
  endtask

  task automatic do_rd();
    rd_done_i = 1; m_ptr = m_ptr + 12'd1;
    tick_chk_ptr("R9");
  endtask

  task automatic do_start();
    start_i = 1; m_mask = '0;
    tick_chk_ptr("R10");
  endtask

  task automatic do_stop();
    logic fire;
    logic [255:0] img;
    fire = (m_mask != '0);
    img = exp_image();
    stop_i = 1;
    tick_chk_ptr("R7");
    chk(cmt_valid_o == fire, fire ? "R4" : "R5", 256'(cmt_valid_o), 256'(fire));
    if (fire) begin
      chk(cmt_page_o == m_ptr[11:5], "R4", 256'(cmt_page_o), 256'(m_ptr[11:5]));
      chk(cmt_mask_o == m_mask, "R6", 256'(cmt_mask_o), 256'(m_mask));
      chk(cmt_data_o == img, "R3", cmt_data_o, img);
    end
    m_mask = '0;
    @(negedge clk);
    chk(cmt_valid_o == 1'b0, "R4", 256'(cmt_valid_o), 256'(0));
  endtask

  initial begin : watchdog
    #(10 * 150000);
    n_err++;
    $display("FAIL watchdog R1 act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    int unsigned r;
    for (int k = 0; k < 32; k++) m_buf[k] = '0;
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_addr_o == 12'd0, "R1", 256'(rd_addr_o), 256'(0));
    chk(cmt_valid_o == 1'b0, "R1", 256'(cmt_valid_o), 256'(0));
    do_stop();                       // R1/R5: empty buffer after reset

    // R2 wrap within page, R7 pointer after commit
    do_start(); do_load(12'h7FE);
    do_wr(8'hA1); do_wr(8'hA2); do_wr(8'hA3);
    chk(rd_addr_o == 12'h7E1, "R2", 256'(rd_addr_o), 256'(12'h7E1));
    do_stop();
    chk(rd_addr_o == 12'h7E1, "R7", 256'(rd_addr_o), 256'(12'h7E1));

    // R3 overflow: 34 bytes, offsets 0 and 1 rewritten
    do_start(); do_load(12'h100);
    for (int i = 0; i < 34; i++) do_wr(8'(i + 8'h40));
    do_stop();

    // R6 partial page, R8/R9 dummy write then sequential read across 4095
    do_start(); do_load(12'hC45); do_wr(8'h5A); do_stop();
    do_start(); do_load(12'hFFE); do_start();
    do_rd(); do_rd(); do_rd();
    chk(rd_addr_o == 12'h001, "R9", 256'(rd_addr_o), 256'(12'h001));
    do_stop();                       // R5 after a read

    // R10 start drops pending bytes
    do_start(); do_load(12'h222); do_wr(8'h11); do_wr(8'h22);
    do_start(); do_stop();

    // random mix
    for (int i = 0; i < 400; i++) begin
      r = $urandom % 100;
      if (r < 50)      do_wr(8'($urandom));
      else if (r < 60) do_load(12'($urandom));
      else if (r < 80) do_rd();
      else if (r < 90) do_stop();
      else             do_start();
    end
    do_stop();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule